// File: doc/BRIEF.md
# Transmit Holding FIFO with Programmable Empty-Space Interrupt

This block holds the bytes a CPU writes for one UART transmit channel until the transmit shifter takes them. The holding depth is picked at run time as 8 or 16 entries by a single select input. The oldest byte is always shown on the head output, and the shifter pulses a dequeue strobe to remove it.

The block raises an interrupt request when enough entries are free. A 2-bit threshold code sets how much free space is needed, and the meaning of each code scales with the selected depth. The request is only driven while the transmitter is enabled. Two status flags show whether at least one entry is free and whether the FIFO is completely empty. Any change of the depth select empties the FIFO.

Top module: `tx_fifo_thr`

## Requirements
- R1: After reset the FIFO is empty, the depth is 8, `tx_empty`=1 and `tx_rdy`=1. With threshold code 00, `irq` goes high as soon as `tx_en`=1.
- R2: Bytes leave in the order they were written. `head_data` shows the oldest stored byte whenever the FIFO is not empty.
- R3: `depth_sel`=0 gives a capacity of 8 entries and `depth_sel`=1 gives 16. `tx_rdy` is 1 exactly while fewer than that many bytes are stored.
- R4: A write while the FIFO is full is dropped. Neither the stored bytes nor the count change.
- R5: A dequeue while the FIFO is empty has no effect. A later write then shows its byte at the head.
- R6: At depth 8, `irq` = `tx_en` AND (free entries meet the threshold). Codes 00/01/10/11 need 8, ≥4, ≥6 and ≥1 free entries.
- R7: At depth 16, codes 00/01/10/11 need 16, ≥8, ≥12 and ≥1 free entries.
- R8: `irq` is 0 while `tx_en`=0, at any fill level and with any code.
- R9: A clock edge at which `depth_sel` differs from the current depth adopts the new depth and empties the FIFO. A write or dequeue in that cycle is ignored.
- R10: A write and a dequeue in the same cycle, with the FIFO neither empty nor full, keep the count and keep the byte order.
- R11: With code 11, `irq` equals `tx_en` AND `tx_rdy`. With code 00, `irq` equals `tx_en` AND `tx_empty`.
- R12: `tx_empty` is 1 exactly when no bytes are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | Byte to enqueue |
| rd_en | input | 1 | Dequeue strobe from the shifter |
| tx_en | input | 1 | Transmitter enable; gates the interrupt |
| depth_sel | input | 1 | 0 = 8 entries, 1 = 16 entries |
| thr_code | input | 2 | Free-space threshold code |
| head_data | output | 8 | Oldest stored byte |
| tx_rdy | output | 1 | At least one entry free |
| tx_empty | output | 1 | No byte stored |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count shows up on the first cycle after the faulty update, because `tx_rdy`, `tx_empty` and `irq` all decode the count combinationally. A wrong pointer is different: it only shows when the affected entry reaches the head. For that reason, every fill is drained back out and each head byte is compared. The bench sweeps every fill level of both depths against all four codes and both enable values. This catches an error in the threshold table at the exact boundary where the request should change.

// File: rtl/txf_pkg.sv
package txf_pkg;
    typedef enum logic [1:0] {
        THR_ALL  = 2'b00,
        THR_HALF = 2'b01,
        THR_3Q   = 2'b10,
        THR_ONE  = 2'b11
    } thr_code_e;
endpackage

// File: rtl/txf_store.sv
module txf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl #(
    parameter int DEPTH_HI = 16,
    localparam int PTR_W = $clog2(DEPTH_HI),
    localparam int CNT_W = $clog2(DEPTH_HI + 1),
    localparam int DEPTH_LO = DEPTH_HI / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             depth_sel,
    output logic             wr_go,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap
);
    typedef struct packed {
        logic             deep;
        logic [PTR_W-1:0] rp;
        logic [PTR_W-1:0] wp;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   full, empty, flush, rd_go;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                              input logic [CNT_W-1:0] lim);
        return (CNT_W'(p) == lim - 1'b1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cap   = st_q.deep ? CNT_W'(DEPTH_HI) : CNT_W'(DEPTH_LO);
        full  = (st_q.cnt == cap);
        empty = (st_q.cnt == '0);
        flush = (depth_sel != st_q.deep);
        wr_go = wr_en && !full && !flush;
        rd_go = rd_en && !empty && !flush;
        st_d  = st_q;
        if (flush) begin
            st_d.deep = depth_sel;
            st_d.rp   = '0;
            st_d.wp   = '0;
            st_d.cnt  = '0;
        end else begin
            if (wr_go) st_d.wp = bump(st_q.wp, cap);
            if (rd_go) st_d.rp = bump(st_q.rp, cap);
            st_d.cnt = st_q.cnt + CNT_W'(wr_go) - CNT_W'(rd_go);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wptr = st_q.wp;
    assign rptr = st_q.rp;
    assign cnt  = st_q.cnt;

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= cap);
    assert_full_wr_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !flush) |=> (st_q.cnt == $past(st_q.cnt)));
    assert_empty_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en && !flush) |=> (st_q.cnt == '0));
    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0 && st_q.rp == st_q.wp));
endmodule

// File: rtl/txf_irq.sv
module txf_irq #(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cap,
    input  logic [1:0]       thr,
    input  logic             tx_en,
    output logic             irq
);
    import txf_pkg::*;
    logic [CNT_W-1:0] free_n, need;

    always_comb begin
        free_n = cap - cnt;
        case (thr_code_e'(thr))
            THR_ALL:  need = cap;
            THR_HALF: need = cap >> 1;
            THR_3Q:   need = cap - (cap >> 2);
            default:  need = CNT_W'(1);
        endcase
        irq = tx_en && (free_n >= need);
    end
endmodule

// File: rtl/tx_fifo_thr.sv
module tx_fifo_thr #(
    parameter int DATA_W   = 8,
    parameter int DEPTH_HI = 16,
    localparam int PTR_W = $clog2(DEPTH_HI),
    localparam int CNT_W = $clog2(DEPTH_HI + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              tx_en,
    input  logic              depth_sel,
    input  logic [1:0]        thr_code,
    output logic [DATA_W-1:0] head_data,
    output logic              tx_rdy,
    output logic              tx_empty,
    output logic              irq
);
    logic             wr_go;
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt, cap;

    txf_ctrl #(.DEPTH_HI(DEPTH_HI)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .depth_sel(depth_sel), .wr_go(wr_go), .wptr(wptr), .rptr(rptr),
        .cnt(cnt), .cap(cap)
    );

    txf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH_HI)) u_store (
        .clk(clk), .we(wr_go), .waddr(wptr), .wdata(wr_data),
        .raddr(rptr), .rdata(head_data)
    );

    txf_irq #(.CNT_W(CNT_W)) u_irq (
        .cnt(cnt), .cap(cap), .thr(thr_code), .tx_en(tx_en), .irq(irq)
    );

    assign tx_rdy   = (cnt != cap);
    assign tx_empty = (cnt == '0);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !irq);
    assert_one_is_rdy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_code == 2'b11) |-> (irq == (tx_en && tx_rdy)));
    assert_all_is_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_code == 2'b00) |-> (irq == (tx_en && tx_empty)));
    assert_empty_has_room_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_rdy);
endmodule

// File: tb/tx_fifo_thr_tb.sv
`timescale 1ns/1ps
module tx_fifo_thr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, tx_en = 1'b0, depth_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] thr_code = 2'b00;
    logic [7:0] head_data;
    logic       tx_rdy, tx_empty, irq;
    int         n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    tx_fifo_thr u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .tx_en(tx_en), .depth_sel(depth_sel),
        .thr_code(thr_code), .head_data(head_data), .tx_rdy(tx_rdy),
        .tx_empty(tx_empty), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int d, input int i);
        return d ? 8'(8'h80 + i * 5) : 8'(8'h10 + i * 3);
    endfunction

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 empty after reset", tx_empty, 1);
        chk("R1 rdy after reset", tx_rdy, 1);
        chk("R8 irq low while disabled", irq, 0);
        tx_en = 1'b1; #1;
        chk("R1 irq on enable", irq, 1);

        for (int d = 0; d < 2; d++) begin
            int cap;
            cap = d ? 16 : 8;
            @(negedge clk); depth_sel = d[0];
            @(negedge clk);
            for (int k = 0; k <= cap; k++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int e = 0; e < 2; e++) begin
                        int need, exp;
                        need = (c == 0) ? cap : (c == 1) ? cap / 2 :
                               (c == 2) ? cap * 3 / 4 : 1;
                        exp = (e == 1 && (cap - k) >= need) ? 1 : 0;
                        thr_code = c[1:0]; tx_en = e[0]; #1;
                        chk(d ? "R7 threshold 16-deep" : "R6 threshold 8-deep", irq, exp);
                        if (e == 0) chk("R8 disabled gate", irq, 0);
                    end
                end
                chk("R3 tx_rdy vs fill", tx_rdy, (k < cap) ? 1 : 0);
                chk("R12 tx_empty vs fill", tx_empty, (k == 0) ? 1 : 0);
                if (k < cap) push(pat(d, k));
            end
            push(8'hEE);
            chk("R4 still full", tx_rdy, 0);
            for (int i = 0; i < cap; i++) begin
                #1;
                chk("R2 head order", head_data, pat(d, i));
                chk("R4 not empty before drain end", tx_empty, 0);
                pop();
            end
            #1;
            chk("R4 empty after cap bytes", tx_empty, 1);
            pop(); #1;
            chk("R5 dequeue on empty", tx_empty, 1);
            chk("R5 rdy on empty", tx_rdy, 1);
            push(8'h5A); #1;
            chk("R5 head after empty dequeue", head_data, 8'h5A);
            chk("R5 count one", tx_empty, 0);
            pop();
        end

        // depth change flushes (currently 16 deep)
        for (int i = 0; i < 5; i++) push(8'(i + 1));
        @(negedge clk); depth_sel = 1'b0; wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk); wr_en = 1'b0;
        thr_code = 2'b00; tx_en = 1'b1; #1;
        chk("R9 flushed on depth change", tx_empty, 1);
        chk("R9 irq code 00 after flush", irq, 1);
        for (int i = 0; i < 8; i++) push(8'(i + 8'h20));
        #1;
        chk("R9 R3 new depth 8 full", tx_rdy, 0);
        for (int i = 0; i < 8; i++) pop();

        // simultaneous write and dequeue
        push(8'h11); push(8'h22); push(8'h33);
        @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h44;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; #1;
        chk("R10 head after concurrent", head_data, 8'h22);
        thr_code = 2'b10; #1;
        chk("R10 count kept (5 free <6)", irq, 0);
        thr_code = 2'b01; #1;
        chk("R10 count kept (5 free >=4)", irq, 1);
        pop(); #1; chk("R10 order", head_data, 8'h33);
        pop(); #1; chk("R10 order", head_data, 8'h44);
        pop(); #1; chk("R10 drained", tx_empty, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule